// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Generator

This block runs external code-fetch, data-read and data-write cycles on a multiplexed address/data port. It is clocked at the oscillator rate, so every bus phase is a whole number of clock periods. An internal master hands in one request at a time over a valid/ready handshake. The block puts the low address byte on the shared port and the upper bits on a dedicated port. It pulses the address latch enable, then lowers exactly one strobe: program-store enable for a fetch, read for a data read, or write for a data write.

For fetches and reads the shared port is released while the strobe is low. The byte present in the last strobe cycle is returned with a one-cycle response pulse. For writes the data byte is driven for the whole strobe and for one further cycle after it. Two wait-state controls are sampled when a request is accepted. One lengthens the address-latch pulse by two periods. The other, a count N from 0 to 3, lengthens the strobe by 2×N periods.

Top module: `mbus_engine`

## Requirements
- R1: During and after reset, ale is low, rd_n, wr_n and psen_n are high, ad_oe is low, rsp_valid is low and req_ready is high.
- R2: After a request is accepted, ale is high for 1 cycle when cfg_ale_stretch was 0 and 3 cycles when it was 1. While ale is high, ad_out carries addr[7:0] with ad_oe high, and addr_hi carries addr[15:8].
- R3: Exactly one cycle follows the fall of ale in which ad_oe stays high with the low address on ad_out and every strobe stays high. No strobe is ever low while ale is high.
- R4: The strobe stays low for 2+2×N consecutive cycles, where N is cfg_strobe_wait (0 to 3) sampled at acceptance.
- R5: req_kind selects the strobe: 2'b00 lowers psen_n (fetch), 2'b01 lowers rd_n (read), 2'b10 and 2'b11 lower wr_n (write). At most one strobe is low at any time.
- R6: For a fetch or read, ad_oe is low for every cycle in which the strobe is low.
- R7: For a fetch or read, the byte on ad_in in the last strobe-low cycle is presented on rsp_data. It appears in the single cycle after the strobe rises, with rsp_valid high for exactly that one cycle.
- R8: For a write, ad_out carries the request's wdata with ad_oe high for every strobe-low cycle and for the one cycle after wr_n rises. rsp_valid stays low for writes.
- R9: req_ready is low from the cycle after acceptance until the cycle is complete. One recovery cycle with all strobes high and ale low separates the strobe's rise from the next ale rise. A request held valid back-to-back is accepted in the first ready cycle.
- R10: Changes to cfg_ale_stretch or cfg_strobe_wait after acceptance do not alter the cycle in progress.
- R11: Once a cycle ends the block is idle: req_ready high, all strobes high, ale low and ad_oe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 00 fetch, 01 read, 1x write |
| req_addr | input | ADDR_W | Bus address |
| req_wdata | input | DATA_W | Write data |
| cfg_ale_stretch | input | 1 | Lengthen ale by two periods |
| cfg_strobe_wait | input | WAIT_W | Strobe wait count N |
| rsp_valid | output | 1 | One-cycle read/fetch data pulse |
| rsp_data | output | DATA_W | Returned byte |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| psen_n | output | 1 | Code fetch strobe, active low |
| ad_out | output | DATA_W | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | DATA_W | Shared port input value |
| addr_hi | output | ADDR_W-DATA_W | Upper address bits |

## Verification
The bench uses the default parameters: a 16-bit address split into two 8-bit halves and a 2-bit strobe wait count. With these values all four strobe lengths (2, 4, 6 and 8 cycles) and both latch-pulse lengths are reachable, under every request kind. The bench drives a different byte on ad_in in each strobe cycle, so a capture taken one cycle early or late returns a visibly wrong value. Directed runs change the wait settings in the middle of a cycle and issue back-to-back requests.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_HOLD,
    PH_STROBE,
    PH_RECOVER
  } phase_t;

  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_READ  = 2'b01;

  // Length of the latch-enable pulse in clock periods.
  function automatic int unsigned ale_cycles(input logic stretch);
    return stretch ? 3 : 1;
  endfunction

  // Length of the strobe-low window in clock periods for wait count n.
  function automatic int unsigned strobe_cycles(input int unsigned n);
    return 2 + 2 * n;
  endfunction

  function automatic logic kind_is_write(input logic [1:0] kind);
    return kind[1];
  endfunction

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stretch,
  input  logic [WAIT_W-1:0] wait_n,
  output phase_t            phase,
  output logic              last_strobe
);
  localparam int CNT_W = WAIT_W + 1;

  phase_t            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WAIT_W-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wait_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_ADDR;
          cnt_q   <= CNT_W'(ale_cycles(stretch) - 1);
          wait_q  <= wait_n;
        end
        PH_ADDR: begin
          if (cnt_q == '0) phase_q <= PH_HOLD;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        PH_HOLD: begin
          phase_q <= PH_STROBE;
          cnt_q   <= CNT_W'(strobe_cycles(32'(wait_q)) - 1);
        end
        PH_STROBE: begin
          if (cnt_q == '0) phase_q <= PH_RECOVER;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        PH_RECOVER: phase_q <= PH_IDLE;
        default:    phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase       = phase_q;
  assign last_strobe = (phase_q == PH_STROBE) && (cnt_q == '0);

endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  phase_t                    phase,
  input  logic [1:0]                kind,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic                      ale,
  output logic                      rd_n,
  output logic                      wr_n,
  output logic                      psen_n,
  output logic [DATA_W-1:0]         ad_out,
  output logic                      ad_oe,
  output logic [ADDR_W-DATA_W-1:0]  addr_hi
);
  logic addr_phase;
  logic strobe_on;
  logic is_wr;

  always_comb begin
    is_wr      = kind_is_write(kind);
    addr_phase = (phase == PH_ADDR) || (phase == PH_HOLD);
    strobe_on  = (phase == PH_STROBE);
    ale        = (phase == PH_ADDR);
    psen_n     = !(strobe_on && kind == KIND_FETCH);
    rd_n       = !(strobe_on && kind == KIND_READ);
    wr_n       = !(strobe_on && is_wr);
    if (addr_phase) begin
      ad_out = addr[DATA_W-1:0];
      ad_oe  = 1'b1;
    end else if (is_wr && (strobe_on || phase == PH_RECOVER)) begin
      ad_out = wdata;
      ad_oe  = 1'b1;
    end else begin
      ad_out = '0;
      ad_oe  = 1'b0;
    end
    addr_hi = addr[ADDR_W-1:DATA_W];
  end

endmodule

// File: rtl/mbus_capture.sv
module mbus_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= sample;
      if (sample) rsp_data <= ad_in;
    end
  end
endmodule

// File: rtl/mbus_engine.sv
module mbus_engine
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     cfg_ale_stretch,
  input  logic [WAIT_W-1:0]        cfg_strobe_wait,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     psen_n,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] addr_hi
);
  phase_t            phase;
  logic              last_strobe;
  logic              accept;
  logic              read_sample;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready   = (phase == PH_IDLE);
  assign accept      = req_valid && req_ready;
  assign read_sample = last_strobe && !kind_is_write(kind_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= KIND_READ;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      kind_q  <= req_kind;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  mbus_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .stretch     (cfg_ale_stretch),
    .wait_n      (cfg_strobe_wait),
    .phase       (phase),
    .last_strobe (last_strobe)
  );

  mbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .phase   (phase),
    .kind    (kind_q),
    .addr    (addr_q),
    .wdata   (wdata_q),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .psen_n  (psen_n),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .addr_hi (addr_hi)
  );

  mbus_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample    (read_sample),
    .ad_in     (ad_in),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/mbus_engine_checker.sv
module mbus_engine_checker (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic psen_n,
  input logic ad_oe
);
  logic any_strobe;
  assign any_strobe = !rd_n || !wr_n || !psen_n;

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!rd_n, !wr_n, !psen_n}) <= 1);

  assert_no_ale_with_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !any_strobe);

  assert_read_after_ale_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(psen_n)) |-> !$past(ale));

  assert_port_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !ad_oe);

  assert_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe);

  assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!rd_n || !psen_n));

  assert_ale_after_recover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> $past(!any_strobe));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ale && !any_strobe && !ad_oe));

endmodule

bind mbus_engine mbus_engine_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .psen_n    (psen_n),
  .ad_oe     (ad_oe)
);

// File: tb/mbus_engine_test.sv
module mbus_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {kind[36:35], stretch[34], wait[33:32], addr[31:16], wdata[15:8], base[7:0]}
  localparam logic [36:0] VECS [NVEC] = '{
    {2'b00, 1'b0, 2'd0, 16'h1234, 8'h00, 8'h40},
    {2'b01, 1'b0, 2'd1, 16'hA55A, 8'h00, 8'h80},
    {2'b10, 1'b0, 2'd2, 16'h0F0F, 8'hC3, 8'h00},
    {2'b01, 1'b1, 2'd3, 16'hFFFF, 8'h00, 8'h10},
    {2'b10, 1'b1, 2'd0, 16'h0001, 8'h5A, 8'h00},
    {2'b00, 1'b1, 2'd2, 16'h8000, 8'h00, 8'h20},
    {2'b11, 1'b0, 2'd3, 16'h7E81, 8'hA5, 8'h00},
    {2'b01, 1'b1, 2'd1, 16'h00FF, 8'h00, 8'hE0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = 2'b00;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic cfg_ale_stretch = 1'b0;
  logic [1:0] cfg_strobe_wait = '0;
  logic rsp_valid;
  logic [7:0] rsp_data;
  logic ale, rd_n, wr_n, psen_n, ad_oe;
  logic [7:0] ad_out;
  logic [7:0] ad_in = '0;
  logic [7:0] addr_hi;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_ale_stretch(cfg_ale_stretch), .cfg_strobe_wait(cfg_strobe_wait),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .psen_n(psen_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .addr_hi(addr_hi)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk(req_ready && !ale && rd_n && wr_n && psen_n && !ad_oe && !rsp_valid, tag,
        {req_ready, ale, rd_n, wr_n, psen_n, ad_oe, rsp_valid}, 7'b1011100);
  endtask

  // Issues one request at a negedge and follows it cycle by cycle.
  task automatic run_cycle(input logic [1:0] kind, input logic st, input logic [1:0] n,
                           input logic [15:0] addr, input logic [7:0] wd,
                           input logic [7:0] base, input bit flip_cfg);
    int ale_cnt = 0, hold_cnt = 0, stb_cnt = 0, rec_cnt = 0, guard = 0;
    int exp_stb = 2 + 2 * n;
    bit is_wr = kind[1];
    bit own_low, others_high;
    chk(req_ready, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
    cfg_ale_stretch = st; cfg_strobe_wait = n;
    @(negedge clk);
    req_valid = 1'b0;
    if (flip_cfg) begin
      cfg_ale_stretch = !st;
      cfg_strobe_wait = ~n;
    end
    while (!req_ready && guard < 64) begin
      guard++;
      chk(addr_hi == addr[15:8], "R2 addr_hi", addr_hi, addr[15:8]);
      own_low = (kind == 2'b00) ? !psen_n : (kind == 2'b01) ? !rd_n : !wr_n;
      others_high = ({rd_n, wr_n, psen_n} == 3'b111) || own_low &&
                    ($countones({!rd_n, !wr_n, !psen_n}) == 1);
      chk(others_high, "R5 strobe select", {rd_n, wr_n, psen_n}, 0);
      if (ale) begin
        ale_cnt++;
        chk(stb_cnt == 0 && hold_cnt == 0, "R3 ale before strobe", stb_cnt, 0);
        chk(ad_oe && ad_out == addr[7:0], "R2 low address on port", ad_out, addr[7:0]);
        chk(!rsp_valid, "R7 no early response", rsp_valid, 0);
      end else if (own_low) begin
        stb_cnt++;
        if (is_wr) chk(ad_oe && ad_out == wd, "R8 write data driven", ad_out, wd);
        else chk(!ad_oe, "R6 port released", ad_oe, 0);
        ad_in = base + 8'(stb_cnt - 1);
      end else if (stb_cnt == 0) begin
        hold_cnt++;
        chk(ad_oe && ad_out == addr[7:0], "R3 address hold", ad_out, addr[7:0]);
      end else begin
        rec_cnt++;
        chk(!ale, "R9 no ale in recovery", ale, 0);
        if (is_wr) begin
          chk(ad_oe && ad_out == wd, "R8 write hold", ad_out, wd);
          chk(!rsp_valid, "R8 no response on write", rsp_valid, 0);
        end else begin
          chk(rsp_valid, "R7 response valid", rsp_valid, 1);
          chk(rsp_data == base + 8'(exp_stb - 1), "R7 last-cycle sample",
              rsp_data, base + 8'(exp_stb - 1));
        end
      end
      @(negedge clk);
    end
    chk(ale_cnt == (st ? 3 : 1), "R2 ale length", ale_cnt, st ? 3 : 1);
    chk(hold_cnt == 1, "R3 hold cycles", hold_cnt, 1);
    chk(stb_cnt == exp_stb, "R4 strobe length", stb_cnt, exp_stb);
    chk(rec_cnt == 1, "R9 recovery cycles", rec_cnt, 1);
    check_idle("R11 idle after cycle");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    check_idle("R1 idle in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 idle after reset");

    for (int i = 0; i < NVEC; i++) begin
      logic [36:0] v = VECS[i];
      run_cycle(v[36:35], v[34], v[33:32], v[31:16], v[15:8], v[7:0], 1'b0);
    end

    // R10: settings changed after acceptance, both directions
    run_cycle(2'b01, 1'b0, 2'd0, 16'h3C3C, 8'h00, 8'h66, 1'b1);
    run_cycle(2'b10, 1'b1, 2'd3, 16'hC3C3, 8'h99, 8'h00, 1'b1);

    // R9: back-to-back requests, second taken in the first ready cycle
    run_cycle(2'b00, 1'b0, 2'd1, 16'h2468, 8'h00, 8'h30, 1'b0);
    run_cycle(2'b01, 1'b1, 2'd0, 16'h1357, 8'h00, 8'h70, 1'b0);

    // R1: reset in the middle of a cycle returns to idle
    req_valid = 1'b1; req_kind = 2'b10; cfg_strobe_wait = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R1 idle on mid-cycle reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R11 idle after release");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule